// File: doc/BRIEF.md
# Single-Wire Return-to-One Bus Responder

This block is the target side of a single-wire, open-drain serial bus. It samples the shared line with the system clock and measures how long each low pulse lasts. It recognises a long low pulse as a break that opens a transaction. It then decodes the pulse-width-coded bit slots that follow. The first byte is a command. Its upper bit selects the direction and its lower seven bits select a register. The block then either takes one data byte from the host or returns one data byte by pulling the line low itself.

A register-port interface connects the block to a local register file. The port has an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data is sampled from the register file in the cycle the read strobe is high. Each transaction moves exactly one byte. The block never starts a transaction on its own.

Top module: `swire_resp`

## Requirements
- R1: Out of reset, `line_pull_o`, `reg_we_o` and `reg_re_o` are all 0.
- R2: Low pulses that arrive without a preceding break have no effect on the ports. This covers pulses before the first break and pulses after a completed transaction. No strobe fires and the line is never pulled.
- R3: A low pulse of at least `BREAK_CYC` clock cycles is a break. A break starts a fresh command byte from any state.
- R4: A bit slot whose low time is shorter than `BIT_THR` cycles decodes as 1. A low time from `BIT_THR` up to `BREAK_CYC-1` cycles decodes as 0. Every byte is sent least significant bit first.
- R5: Command bits 6..0 carry the register address. Command bit 7 set to 1 means a write and 0 means a read. `reg_we_o` and `reg_re_o` are never high together.
- R6: After the eighth data bit of a write, `reg_we_o` is high for exactly one cycle, with the command's address on `reg_addr_o` and the received byte on `reg_wdata_o`.
- R7: After the eighth bit of a read command, `reg_re_o` is high for exactly one cycle with the address on `reg_addr_o`. `reg_rdata_i` is captured in that cycle.
- R8: On a read, `line_pull_o` first rises in the clock cycle that comes `TURN_CYC+1` cycles after the cycle in which `reg_re_o` is high.
- R9: The returned byte goes out least significant bit first in slots of `TX_SLOT` cycles. In each slot the line is pulled for `TX_LOW1` cycles to send a 1 or for `TX_LOW0` cycles to send a 0. After eight slots the line stays released.
- R10: A break during any phase, including while the block is pulling the line, releases the line within one cycle. It discards the partial byte without any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared line (1 = released) |
| line_pull_o | output | 1 | 1 pulls the shared line low |
| reg_addr_o | output | ADDR_W | Register address of the current transaction |
| reg_wdata_o | output | DATA_W | Byte to write, valid with `reg_we_o` |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | DATA_W | Register contents at `reg_addr_o`, sampled with `reg_re_o` |

## Verification
Break detection and slot transmission can land in the same cycle. A break may be recognised exactly when the transmitter would start or continue a slot, and the break must win. The bench provokes this by letting the responder begin a read reply and then holding the line low past the break length on top of the responder's own pull. It judges the result by counting cycles of `line_pull_o` after the break, which must stay at zero. It also checks that a complete write issued right after the break lands with the new address and data.

// File: rtl/swr_pkg.sv
package swr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_WDATA = 3'd2,
        ST_TURN  = 3'd3,
        ST_RDATA = 3'd4
    } swr_state_e;

endpackage

// File: rtl/swr_line_meter.sv
// Synchronises the bus level, measures each low pulse and classifies it
// as a data bit (on release) or a break (once the pulse gets long enough).
module swr_line_meter #(
    parameter int BREAK_CYC = 40,
    parameter int BIT_THR   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic bit_vld_o,
    output logic bit_o,
    output logic brk_o
);
    localparam int CW = $clog2(BREAK_CYC + 1);
    localparam logic [CW-1:0] BRK_L  = CW'(BREAK_CYC);
    localparam logic [CW-1:0] BRK_M1 = CW'(BREAK_CYC - 1);
    localparam logic [CW-1:0] THR_L  = CW'(BIT_THR);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] low_cnt;
    } meter_t;

    meter_t q, d;
    logic   rise;

    always_comb begin
        d        = q;
        d.sync   = {q.sync[0], line_i};
        d.lvl    = q.sync[1];
        if (!q.sync[1]) begin
            d.low_cnt = (q.low_cnt == BRK_L) ? q.low_cnt : q.low_cnt + 1'b1;
        end else begin
            d.low_cnt = '0;
        end
        rise      = q.sync[1] && !q.lvl;
        bit_vld_o = rise && (q.low_cnt != '0) && (q.low_cnt < BRK_L);
        bit_o     = (q.low_cnt < THR_L);
        brk_o     = !q.sync[1] && (q.low_cnt == BRK_M1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, lvl: 1'b1, low_cnt: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/swr_slot_tx.sv
// Drives one return-to-one bit slot: short or long pull, then release.
module swr_slot_tx #(
    parameter int LOW1 = 5,
    parameter int LOW0 = 20,
    parameter int SLOT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bit_i,
    input  logic kill_i,
    output logic pull_o,
    output logic done_o
);
    localparam int TW = $clog2(SLOT + 1);
    localparam logic [TW-1:0] END1  = TW'(LOW1 - 1);
    localparam logic [TW-1:0] END0  = TW'(LOW0 - 1);
    localparam logic [TW-1:0] SLOTE = TW'(SLOT - 1);

    typedef struct packed {
        logic          active;
        logic          pull;
        logic          val;
        logic [TW-1:0] tmr;
    } slot_t;

    slot_t q, d;
    logic  done;

    always_comb begin
        d    = q;
        done = q.active && (q.tmr == SLOTE);
        if (q.active) begin
            d.tmr = q.tmr + 1'b1;
            if (q.tmr == (q.val ? END1 : END0)) begin
                d.pull = 1'b0;
            end
            if (done) begin
                d.active = 1'b0;
                d.pull   = 1'b0;
            end
        end
        if (start_i) begin
            d.active = 1'b1;
            d.pull   = 1'b1;
            d.val    = bit_i;
            d.tmr    = '0;
        end
        if (kill_i) begin
            d.active = 1'b0;
            d.pull   = 1'b0;
        end
    end

    assign pull_o = q.pull;
    assign done_o = done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/swire_resp.sv
module swire_resp
    import swr_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int BREAK_CYC = 40,
    parameter int BIT_THR   = 12,
    parameter int TX_LOW1   = 5,
    parameter int TX_LOW0   = 20,
    parameter int TX_SLOT   = 30,
    parameter int TURN_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              line_pull_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int CMD_W = ADDR_W + 1;
    localparam int SR_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(SR_W);
    localparam int TMR_W = $clog2(TURN_CYC + 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [TMR_W-1:0] TURN_END = TMR_W'(TURN_CYC);

    typedef struct packed {
        swr_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [SR_W-1:0]    sr;
        logic [ADDR_W-1:0]  addr;
        logic [TMR_W-1:0]   tmr;
        logic               we;
    } ctl_t;

    ctl_t q, d;

    logic            bit_vld_w, bit_w, brk_w;
    logic            tx_start, tx_bit, tx_done;
    logic [SR_W-1:0] sr_new;

    swr_line_meter #(
        .BREAK_CYC (BREAK_CYC),
        .BIT_THR   (BIT_THR)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .bit_vld_o (bit_vld_w),
        .bit_o     (bit_w),
        .brk_o     (brk_w)
    );

    swr_slot_tx #(
        .LOW1 (TX_LOW1),
        .LOW0 (TX_LOW0),
        .SLOT (TX_SLOT)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .bit_i   (tx_bit),
        .kill_i  (brk_w),
        .pull_o  (line_pull_o),
        .done_o  (tx_done)
    );

    always_comb begin
        d             = q;
        d.we          = 1'b0;
        tx_start      = 1'b0;
        tx_bit        = q.sr[0];
        sr_new        = q.sr;
        sr_new[q.cnt] = bit_w;

        unique case (q.st)
            ST_CMD: begin
                if (bit_vld_w) begin
                    d.sr  = sr_new;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CMD_LAST) begin
                        d.cnt  = '0;
                        d.sr   = '0;
                        d.addr = sr_new[ADDR_W-1:0];
                        d.tmr  = '0;
                        d.st   = bit_w ? ST_WDATA : ST_TURN;
                    end
                end
            end
            ST_WDATA: begin
                if (bit_vld_w) begin
                    d.sr  = sr_new;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == DAT_LAST) begin
                        d.cnt = '0;
                        d.we  = 1'b1;
                        d.st  = ST_IDLE;
                    end
                end
            end
            ST_TURN: begin
                if (q.tmr == '0) begin
                    d.sr               = '0;
                    d.sr[DATA_W-1:0]   = reg_rdata_i;
                end
                d.tmr = q.tmr + 1'b1;
                if (q.tmr == TURN_END) begin
                    tx_start = 1'b1;
                    tx_bit   = q.sr[0];
                    d.st     = ST_RDATA;
                    d.cnt    = '0;
                    d.tmr    = '0;
                end
            end
            ST_RDATA: begin
                if (tx_done) begin
                    if (q.cnt == DAT_LAST) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt    = q.cnt + 1'b1;
                        d.sr     = q.sr >> 1;
                        tx_start = 1'b1;
                        tx_bit   = q.sr[1];
                    end
                end
            end
            default: ;
        endcase

        if (brk_w) begin
            d.st     = ST_CMD;
            d.cnt    = '0;
            d.sr     = '0;
            d.tmr    = '0;
            tx_start = 1'b0;
        end
    end

    assign reg_addr_o  = q.addr;
    assign reg_wdata_o = q.sr[DATA_W-1:0];
    assign reg_we_o    = q.we;
    assign reg_re_o    = (q.st == ST_TURN) && (q.tmr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
    parameter int TURN_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic brk,
    input logic reg_we,
    input logic reg_re,
    input logic line_pull
);
    logic        wait_q;
    logic [15:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            cnt_q  <= '0;
        end else if (reg_re) begin
            wait_q <= 1'b1;
            cnt_q  <= 16'd1;
        end else if (wait_q) begin
            if (cnt_q != 16'hFFFF) cnt_q <= cnt_q + 16'd1;
            if (line_pull) wait_q <= 1'b0;
        end
    end

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R6

    AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R5

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !line_pull); // R10

    AST_TURN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && line_pull) |-> (cnt_q == 16'(TURN_CYC + 1))); // R8

endmodule

bind swire_resp swr_checker #(.TURN_CYC(TURN_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk       (brk_w),
    .reg_we    (reg_we_o),
    .reg_re    (reg_re_o),
    .line_pull (line_pull_o)
);

// File: tb/swire_resp_tb.sv
module swire_resp_tb;
    localparam int TURN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_pull = 1'b0;
    logic line_pull_o, reg_we_o, reg_re_o;
    logic [6:0] reg_addr_o;
    logic [7:0] reg_wdata_o, reg_rdata_i;
    logic [7:0] regs [128];
    wire line_w = !(host_pull || line_pull_o);

    always #4 clk = ~clk;

    swire_resp u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_w), .line_pull_o(line_pull_o),
        .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o),
        .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata_i)
    );

    assign reg_rdata_i = regs[reg_addr_o];

    int total = 0, fails = 0;
    bit finished = 0;

    // monitor state (written only by the monitor)
    int cyc = 0, we_cnt = 0, re_cnt = 0, pull_cycles = 0, rx_total = 0, bad_w = 0;
    int run = 0, re_cyc = 0, turn_meas = -1;
    bit turn_wait = 0, pull_prev = 0;
    logic [6:0] w_addr, r_addr;
    logic [7:0] w_data, rx_sr;

    initial for (int i = 0; i < 128; i++) regs[i] = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (reg_we_o) begin
            we_cnt++; w_addr = reg_addr_o; w_data = reg_wdata_o;
            regs[reg_addr_o] = reg_wdata_o;
        end
        if (reg_re_o) begin
            re_cnt++; r_addr = reg_addr_o; re_cyc = cyc; turn_wait = 1;
        end
        if (line_pull_o) begin
            pull_cycles++;
            if (!pull_prev && turn_wait) begin
                turn_meas = cyc - re_cyc; turn_wait = 0;
            end
            run++;
        end else if (pull_prev) begin
            rx_sr = {(run < 12), rx_sr[7:1]};
            if (run != 5 && run != 20) bad_w++;
            rx_total++;
            run = 0;
        end
        pull_prev = line_pull_o;
    end

    task automatic check_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(bit low, int n);
        host_pull = low;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_slot(int lw);
        hold(1, lw);
        hold(0, (30 - lw) > 8 ? (30 - lw) : 8);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_slot(v[i] ? 4 : 20);
    endtask

    task automatic send_break();
        hold(1, 50);
        hold(0, 12);
    endtask

    task automatic do_write(logic [6:0] a, logic [7:0] v);
        send_break();
        send_byte({1'b1, a});
        send_byte(v);
        hold(0, 5);
    endtask

    task automatic do_read(logic [6:0] a, output logic [7:0] v);
        int start = rx_total;
        send_break();
        send_byte({1'b0, a});
        for (int k = 0; k < 600 && rx_total < start + 8; k++) @(negedge clk);
        v = rx_sr;
        hold(0, 30);
    endtask

    // {write flag, address, data}
    localparam logic [15:0] VEC [8] = '{
        16'h85A5, 16'hFF3C, 16'h80FF, 16'h9200,
        16'h05A5, 16'h7F3C, 16'h00FF, 16'h1200
    };

    initial begin
        logic [7:0] got;
        int we0, re0, p0, bw0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1 pull", line_pull_o, 0);
        check_eq("R1 we", reg_we_o, 0);
        check_eq("R1 re", reg_re_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 pull after release", line_pull_o, 0);

        // R2: bits before any break are ignored
        we0 = we_cnt; re0 = re_cnt; p0 = pull_cycles;
        send_byte(8'h85); send_byte(8'h11); hold(0, 60);
        check_eq("R2 we", we_cnt, we0);
        check_eq("R2 re", re_cnt, re0);
        check_eq("R2 pull", pull_cycles, p0);

        // table of transactions
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][15]) begin
                we0 = we_cnt;
                do_write(VEC[i][14:8], VEC[i][7:0]);
                check_eq("R6 write strobe count", we_cnt, we0 + 1);
                check_eq("R5 write address", w_addr, VEC[i][14:8]);
                check_eq("R4 write data", w_data, VEC[i][7:0]);
            end else begin
                re0 = re_cnt; bw0 = bad_w;
                do_read(VEC[i][14:8], got);
                check_eq("R7 read strobe count", re_cnt, re0 + 1);
                check_eq("R5 read address", r_addr, VEC[i][14:8]);
                check_eq("R9 returned byte", got, VEC[i][7:0]);
                check_eq("R9 slot low widths", bad_w, bw0);
                check_eq("R8 turnaround", turn_meas, TURN + 1);
            end
        end

        // R4: decode threshold corners (11 -> 1, 12 -> 0, 39 -> 0)
        we0 = we_cnt;
        send_break();
        send_byte(8'h81);
        send_slot(11); send_slot(12); send_slot(39);
        for (int i = 0; i < 5; i++) send_slot(4);
        hold(0, 5);
        check_eq("R4 threshold count", we_cnt, we0 + 1);
        check_eq("R4 threshold data", w_data, 8'hF9);

        // R10/R3: break in the middle of write data
        we0 = we_cnt;
        send_break();
        send_byte(8'hA2);
        for (int i = 0; i < 4; i++) send_slot(4);
        do_write(7'h23, 8'h77);
        check_eq("R10 aborted write count", we_cnt, we0 + 1);
        check_eq("R3 write after abort addr", w_addr, 7'h23);
        do_read(7'h22, got);
        check_eq("R10 aborted register untouched", got, 8'h00);

        // R10: break while the responder drives the line
        begin
            int start = rx_total;
            send_break();
            send_byte(8'h00);
            for (int k = 0; k < 600 && rx_total < start + 2; k++) @(negedge clk);
            hold(1, 50);
            p0 = pull_cycles;
            hold(0, 200);
            check_eq("R10 no drive after abort", pull_cycles, p0);
            we0 = we_cnt;
            send_byte(8'hC0); send_byte(8'h6C); hold(0, 5);
            check_eq("R3 command after abort count", we_cnt, we0 + 1);
            check_eq("R3 command after abort addr", w_addr, 7'h40);
            check_eq("R3 command after abort data", w_data, 8'h6C);
        end

        // R2: no auto increment, bytes without a new break do nothing
        we0 = we_cnt; re0 = re_cnt; p0 = pull_cycles;
        send_byte(8'h00); send_byte(8'h41); hold(0, 100);
        check_eq("R2 no auto increment we", we_cnt, we0);
        check_eq("R2 no auto increment re", re_cnt, re0);
        check_eq("R2 no auto increment pull", pull_cycles, p0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

endmodule